// File: doc/BRIEF.md
# Waveform Timer/Counter

This block is an 8-bit counter with one compare unit that drives one waveform pin. A 2-bit mode field chooses among four counting schemes. The first is a free-running up counter. The second is an up/down counter for symmetric PWM. The third is an up counter that restarts when it reaches the compare value. The fourth is a single-slope PWM counter. A second 2-bit field selects the pin's reaction to a compare match and, in the PWM schemes, to the counter's TOP. The meaning of that field depends on the scheme in use.

Software writes the mode and pin-action fields together through a configuration strobe, and it writes the compare value through a separate strobe. In the two PWM schemes, a compare write lands in a holding register. The holding register is copied into the active compare register when the counter reaches TOP, so a duty-cycle change never produces a glitch. The holding register can always be read back. Two sticky flags record counter overflow and compare match. Each flag is cleared by its own strobe bit.

Top module: `wavetimer`

## Requirements
- R1: After a synchronous active-low reset, the counter is 0x00 and counts up. Both flags, the pin value, the pin enable, the compare readback and the active compare value are all zero, and the mode field is 00.
- R2: In mode 00 the counter adds one on every clock and wraps from 0xFF to 0x00.
- R3: In mode 10 the counter goes to 0x00 on the clock after the clock on which it equals the active compare value, and otherwise adds one. The compare flag sets on the clock edge at which the counter equals the active compare value.
- R4: In mode 11 the counter runs 0x00 to 0xFF and wraps. Pin code 10 sets the pin when the counter is 0xFF and clears it on a match. Pin code 11 does the opposite.
- R5: In mode 11 with the compare value at 0xFF and pin code 10 or 11, only the TOP action is applied, so the pin holds steady.
- R6: In mode 01 the counter climbs from 0x00 to 0xFF and then falls back to 0x00, with each end value held for one clock. The overflow flag sets at the bottom turn, and does not set at 0xFF.
- R7: In mode 01, a match while climbing clears the pin for code 10 and sets it for code 11. A match while falling does the reverse.
- R8: In modes 00 and 10, a match toggles the pin for code 01, clears it for code 10 and sets it for code 11.
- R9: Pin code 00 in any mode, and code 01 in modes 01 and 11, leave the pin unchanged. The pin enable is high exactly when the pin code is non-zero.
- R10: In modes 00 and 10, a compare write takes effect at once. In modes 01 and 11 it goes only to the holding register, which is copied to the active compare on the clock at which the counter is 0xFF. The readback always shows the holding register.
- R11: Outside R6, the overflow flag sets on the clock edge at which the counter is 0xFF. Both flags stay set until their clear bit is written (bit 0 clears overflow, bit 1 clears compare). A new event in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Strobe that loads cfg_mode and cfg_com |
| cfg_mode | input | 2 | Counting scheme: 00 normal, 01 up/down PWM, 10 clear-on-match, 11 single-slope PWM |
| cfg_com | input | 2 | Pin action code |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_wdata | input | 8 | Compare value to write |
| flag_clr | input | 2 | Flag clear strobes: bit 0 overflow, bit 1 compare |
| cnt | output | 8 | Current counter value |
| cmp_rd | output | 8 | Holding register readback |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare match flag |
| wave_out | output | 1 | Waveform pin value |
| wave_oe | output | 1 | Waveform pin enable |

## Verification
The hardest situation to reach is the buffered compare copy. A write in a PWM scheme must leave the active value alone until the counter passes 0xFF, and the only port that shows the effect is the pin edge one whole period later. The stimulus therefore writes a new duty value in the middle of a period in both PWM schemes. It lets several periods run while a cycle-accurate reference model predicts every pin edge. The up/down scheme's turning points and the fast-PWM case where the compare value equals TOP are reached the same way, by running long enough to cross both ends of the count.

// File: rtl/tmr_pkg.sv
// Package: shared types for the waveform timer.
// Assumes: 2-bit mode encoding is fixed by software convention.
package tmr_pkg;
    typedef enum logic [1:0] {
        WG_NORMAL = 2'b00,
        WG_PHASE  = 2'b01,
        WG_CTC    = 2'b10,
        WG_FAST   = 2'b11
    } wg_mode_e;
endpackage

// File: rtl/tmr_counter.sv
// Module: tmr_counter
// Steps the count for the selected scheme and reports overflow and TOP events.
// Assumes: ocr is the active compare value; count always advances each clock.
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  wg_mode_e     mode,
    input  logic [W-1:0] ocr,
    output logic [W-1:0] cnt,
    output logic         dn,
    output logic         ovf_evt,
    output logic         top_evt
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_nx;
    logic         dn_nx;

    // next count and direction for the current scheme
    always_comb begin
        cnt_nx = cnt + ONE;
        dn_nx  = 1'b0;
        case (mode)
            WG_PHASE: begin
                if (!dn) begin
                    if (cnt == MAXV) begin
                        cnt_nx = MAXV - ONE;
                        dn_nx  = 1'b1;
                    end
                end else if (cnt == '0) begin
                    cnt_nx = ONE;
                end else begin
                    cnt_nx = cnt - ONE;
                    dn_nx  = 1'b1;
                end
            end
            WG_CTC: if (cnt == ocr) cnt_nx = '0;
            default: ;
        endcase
    end

    // event decode: overflow point and buffer update point
    always_comb begin
        ovf_evt = (mode == WG_PHASE) ? (dn && cnt == '0) : (cnt == MAXV);
        top_evt = mode[0] && (cnt == MAXV);
    end

    // count register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            dn  <= 1'b0;
        end else begin
            cnt <= cnt_nx;
            dn  <= dn_nx;
        end
    end

    p_ctc_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == WG_CTC && cnt == ocr) |=> cnt == '0);
    p_pc_turn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == WG_PHASE && !dn && cnt == MAXV) |=> (cnt == MAXV - ONE && dn));
    p_norm_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == WG_NORMAL) |=> cnt == $past(cnt) + ONE);
endmodule

// File: rtl/tmr_ocr.sv
// Module: tmr_ocr
// Holds the compare value: direct load in non-PWM schemes, buffered copy at TOP in PWM.
// Assumes: upd pulses on the clock the counter sits at TOP in a PWM scheme.
module tmr_ocr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         buffered,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic         upd,
    output logic [W-1:0] ocr,
    output logic [W-1:0] hold
);
    // holding register takes every write
    always_ff @(posedge clk) begin
        if (!rst_n)  hold <= '0;
        else if (we) hold <= wdata;
    end

    // active compare: immediate or copied at TOP
    always_ff @(posedge clk) begin
        if (!rst_n)                ocr <= '0;
        else if (!buffered && we)  ocr <= wdata;
        else if (buffered && upd)  ocr <= hold;
    end

    p_buf_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (buffered && !upd) |=> ocr == $past(ocr));
endmodule

// File: rtl/tmr_wave.sv
// Module: tmr_wave
// Drives the waveform pin from compare matches and TOP, per scheme and pin code.
// Assumes: cnt, dn and ocr are the counter's registered state for this cycle.
module tmr_wave
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  wg_mode_e     mode,
    input  logic [1:0]   com,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] ocr,
    input  logic         dn,
    output logic         wave,
    output logic         oe
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic hit, at_max, wave_nx;

    // pin next value
    always_comb begin
        hit     = (cnt == ocr);
        at_max  = (cnt == MAXV);
        wave_nx = wave;
        case (mode)
            WG_FAST: begin
                if (com[1]) begin
                    if (at_max)   wave_nx = ~com[0];
                    else if (hit) wave_nx = com[0];
                end
            end
            WG_PHASE: begin
                if (com[1] && hit) wave_nx = dn ? ~com[0] : com[0];
            end
            default: begin
                if (hit) begin
                    case (com)
                        2'b01:   wave_nx = ~wave;
                        2'b10:   wave_nx = 1'b0;
                        2'b11:   wave_nx = 1'b1;
                        default: ;
                    endcase
                end
            end
        endcase
        oe = |com;
    end

    // pin register
    always_ff @(posedge clk) begin
        if (!rst_n) wave <= 1'b0;
        else        wave <= wave_nx;
    end

    p_off_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (com == 2'b00) |=> $stable(wave));
    p_fast_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == WG_FAST && com == 2'b10 && cnt == MAXV) |=> wave);
endmodule

// File: rtl/wavetimer.sv
// Module: wavetimer (top)
// Timer/counter with one compare unit, four schemes, sticky flags and one pin.
// Assumes: single clock, synchronous active-low reset, strobes last one cycle.
module wavetimer
    import tmr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_we,
    input  logic [1:0]   cfg_mode,
    input  logic [1:0]   cfg_com,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    input  logic [1:0]   flag_clr,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cmp_rd,
    output logic         ovf_flag,
    output logic         cmp_flag,
    output logic         wave_out,
    output logic         wave_oe
);
    wg_mode_e     mode_q;
    logic [1:0]   com_q;
    logic [W-1:0] ocr;
    logic         dn, ovf_evt, top_evt;

    // configuration register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= WG_NORMAL;
            com_q  <= 2'b00;
        end else if (cfg_we) begin
            mode_q <= wg_mode_e'(cfg_mode);
            com_q  <= cfg_com;
        end
    end

    tmr_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .ocr(ocr),
        .cnt(cnt), .dn(dn), .ovf_evt(ovf_evt), .top_evt(top_evt)
    );

    tmr_ocr #(.W(W)) u_ocr (
        .clk(clk), .rst_n(rst_n), .buffered(mode_q[0]), .we(cmp_we),
        .wdata(cmp_wdata), .upd(top_evt), .ocr(ocr), .hold(cmp_rd)
    );

    tmr_wave #(.W(W)) u_wave (
        .clk(clk), .rst_n(rst_n), .mode(mode_q), .com(com_q), .cnt(cnt),
        .ocr(ocr), .dn(dn), .wave(wave_out), .oe(wave_oe)
    );

    // sticky flags, set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            cmp_flag <= 1'b0;
        end else begin
            ovf_flag <= (ovf_flag & ~flag_clr[0]) | ovf_evt;
            cmp_flag <= (cmp_flag & ~flag_clr[1]) | (cnt == ocr);
        end
    end

    p_ovf_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_flag);
    p_cmp_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == ocr) |=> cmp_flag);
    p_flag_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr[0]) |=> ovf_flag);
endmodule

// File: tb/wavetimer_tb.sv
module wavetimer_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0] cnt;
        logic [7:0] rd;
        logic       ovf;
        logic       cmpf;
        logic       wave;
        logic       oe;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic [1:0] cfg_com = 2'b00;
    logic       cmp_we = 1'b0;
    logic [7:0] cmp_wdata = 8'h00;
    logic [1:0] flag_clr = 2'b00;
    logic [7:0] cnt, cmp_rd;
    logic       ovf_flag, cmp_flag, wave_out, wave_oe;

    int    n_tests = 0;
    int    n_fail = 0;
    int    cycles = 0;
    string cur_req = "R1";
    exp_t  q[$];

    wavetimer dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_com(cfg_com), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
        .flag_clr(flag_clr), .cnt(cnt), .cmp_rd(cmp_rd), .ovf_flag(ovf_flag),
        .cmp_flag(cmp_flag), .wave_out(wave_out), .wave_oe(wave_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model state
    logic [1:0] m_mode = 0, m_com = 0;
    logic [7:0] m_cnt = 0, m_ocr = 0, m_buf = 0;
    logic       m_dn = 0, m_wave = 0, m_ovf = 0, m_cmp = 0;

    // driver side: the model predicts each edge and pushes the expectation
    always @(posedge clk) begin
        logic hit, mx, ev_ovf;
        logic [7:0] n_cnt;
        logic n_dn, n_wave;
        exp_t e;
        if (!rst_n) begin
            m_mode = 0; m_com = 0; m_cnt = 0; m_ocr = 0; m_buf = 0;
            m_dn = 0; m_wave = 0; m_ovf = 0; m_cmp = 0;
        end else begin
            hit = (m_cnt == m_ocr);
            mx  = (m_cnt == 8'hFF);
            n_wave = m_wave;
            if (m_mode == 2'b11) begin
                if (m_com[1]) begin
                    if (mx) n_wave = ~m_com[0];
                    else if (hit) n_wave = m_com[0];
                end
            end else if (m_mode == 2'b01) begin
                if (m_com[1] && hit) n_wave = m_dn ? ~m_com[0] : m_com[0];
            end else if (hit) begin
                if (m_com == 2'b01) n_wave = ~m_wave;
                else if (m_com == 2'b10) n_wave = 1'b0;
                else if (m_com == 2'b11) n_wave = 1'b1;
            end
            ev_ovf = (m_mode == 2'b01) ? (m_dn && m_cnt == 8'h00) : mx;
            n_dn = 1'b0;
            n_cnt = m_cnt + 8'd1;
            if (m_mode == 2'b01) begin
                if (!m_dn) begin
                    if (mx) begin n_cnt = 8'hFE; n_dn = 1'b1; end
                end else if (m_cnt == 8'h00) n_cnt = 8'h01;
                else begin n_cnt = m_cnt - 8'd1; n_dn = 1'b1; end
            end else if (m_mode == 2'b10 && hit) n_cnt = 8'h00;
            if (!m_mode[0] && cmp_we) m_ocr = cmp_wdata;
            else if (m_mode[0] && mx) m_ocr = m_buf;
            if (cmp_we) m_buf = cmp_wdata;
            m_ovf = (m_ovf & ~flag_clr[0]) | ev_ovf;
            m_cmp = (m_cmp & ~flag_clr[1]) | hit;
            m_wave = n_wave; m_cnt = n_cnt; m_dn = n_dn;
            if (cfg_we) begin m_mode = cfg_mode; m_com = cfg_com; end
        end
        e.cnt = m_cnt; e.rd = m_buf; e.ovf = m_ovf; e.cmpf = m_cmp;
        e.wave = m_wave; e.oe = |m_com;
        q.push_back(e);
    end

    // monitor: pop and compare away from the active edge
    always @(negedge clk) begin
        exp_t e, a;
        if (q.size() > 0) begin
            e = q.pop_front();
            a.cnt = cnt; a.rd = cmp_rd; a.ovf = ovf_flag; a.cmpf = cmp_flag;
            a.wave = wave_out; a.oe = wave_oe;
            n_tests++;
            if (a !== e) begin
                n_fail++;
                if (n_fail < 20)
                    $display("FAIL %s cycle %0d: actual cnt=%h rd=%h ovf=%b cmp=%b wave=%b oe=%b expected cnt=%h rd=%h ovf=%b cmp=%b wave=%b oe=%b",
                        cur_req, cycles, a.cnt, a.rd, a.ovf, a.cmpf, a.wave, a.oe,
                        e.cnt, e.rd, e.ovf, e.cmpf, e.wave, e.oe);
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp_v);
        n_tests++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [1:0] md, input logic [1:0] cm);
        cfg_mode = md; cfg_com = cm; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wr_cmp(input logic [7:0] v);
        cmp_wdata = v; cmp_we = 1'b1;
        @(negedge clk);
        cmp_we = 1'b0;
    endtask

    task automatic clr_flags();
        flag_clr = 2'b11;
        @(negedge clk);
        flag_clr = 2'b00;
    endtask

    initial begin
        int ones;
        wait_n(3);
        rst_n = 1'b1;
        // R1: reset state seen before the first counting edge
        chk("R1 cnt", cnt, 8'h00);
        chk("R1 flags/pin", {4'b0, ovf_flag, cmp_flag, wave_out, wave_oe}, 8'h00);
        chk("R1 readback", cmp_rd, 8'h00);

        cur_req = "R2";
        wait_n(600);
        chk("R2 overflow flag after wrap", {7'b0, ovf_flag}, 8'h01);
        clr_flags();

        cur_req = "R8";
        wr_cmp(8'h40);
        set_cfg(2'b00, 2'b01);
        wait_n(600);
        set_cfg(2'b00, 2'b10);
        wait_n(300);
        set_cfg(2'b00, 2'b11);
        wait_n(300);

        cur_req = "R3";
        wr_cmp(8'h20);
        set_cfg(2'b10, 2'b01);
        wait_n(300);
        chk("R3 count stays within compare", {7'b0, cnt <= 8'h20}, 8'h01);

        cur_req = "R4";
        set_cfg(2'b11, 2'b10);
        wr_cmp(8'h80);
        wait_n(600);
        set_cfg(2'b11, 2'b11);
        wait_n(600);

        cur_req = "R10";
        wr_cmp(8'h30);
        chk("R10 readback shows held value", cmp_rd, 8'h30);
        wait_n(600);

        cur_req = "R5";
        set_cfg(2'b11, 2'b10);
        wr_cmp(8'hFF);
        wait_n(600);
        ones = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (wave_out) ones++;
        end
        chk("R5 pin held high with compare at TOP", {7'b0, ones == 300}, 8'h01);

        cur_req = "R6";
        wr_cmp(8'h30);
        set_cfg(2'b01, 2'b10);
        clr_flags();
        wait_n(1100);
        cur_req = "R7";
        set_cfg(2'b01, 2'b11);
        wr_cmp(8'hC0);
        wait_n(1100);

        cur_req = "R9";
        set_cfg(2'b11, 2'b01);
        wait_n(2);
        chk("R9 enable for reserved code", {7'b0, wave_oe}, 8'h01);
        wait_n(600);
        set_cfg(2'b01, 2'b01);
        wait_n(600);
        set_cfg(2'b10, 2'b00);
        wait_n(2);
        chk("R9 enable off for code 00", {7'b0, wave_oe}, 8'h00);
        wait_n(300);

        cur_req = "R11";
        set_cfg(2'b00, 2'b00);
        wait_n(300);
        clr_flags();
        wait_n(600);
        clr_flags();
        chk("R11 overflow cleared", {7'b0, ovf_flag}, {7'b0, cnt == 8'h00});
        wait_n(20);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule